// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It reads two page-table entries from memory, one after the other. A walk starts when a request is accepted. The walker reads the first-level entry at an address formed from the table base input and the top index field of the virtual address. If that entry is valid, its frame number locates the second-level table, and the walker reads the leaf entry from it. If either entry is invalid, the walk ends with a page fault that reports the level at which it stopped.

When the leaf entry is valid, the walker marks it as referenced. On a write access it also marks the entry as modified. It stores the entry back to memory only when one of these two bits actually changes. All memory traffic uses one request port with a valid/ready handshake. Read data returns on a separate response strobe. The result is given as a one-cycle pulse that carries either the physical address or the fault.

Top module: `ptw_walker`

## Requirements
- R1: While reset is asserted and in the cycle after it, `req_ready` is 1 and `resp_valid` and `mem_valid` are 0.
- R2: The first memory request of a walk is a read (`mem_we`=0) at address {ptbr[31:12], vaddr[31:22], 2'b00}.
- R3: Table entries are 32 bits wide, with valid at bit 0, used at bit 1, dirty at bit 2 and the frame number at bits 31:12. After a valid first-level entry, the second read is at {entry[31:12], vaddr[21:12], 2'b00}.
- R4: An invalid first-level entry ends the walk with `resp_fault`=1 and `resp_level`=0. No second read and no write are issued.
- R5: An invalid second-level entry ends the walk with `resp_fault`=1 and `resp_level`=1, and no write is issued.
- R6: A successful walk returns `resp_fault`=0 and `resp_paddr` = {leaf[31:12], vaddr[11:0]}.
- R7: On a successful walk the leaf entry is written with its used bit set. On a write access its dirty bit is also set. All other bits keep their values.
- R8: The write-back happens only when the used or dirty bit changes value, and it goes to the same address as the leaf read.
- R9: A request is accepted only when `req_ready` is 1, which holds only while idle. A request held during a walk starts nothing.
- R10: Once `mem_valid` is raised, it stays high with unchanged address, direction and data until `mem_ready` is seen.
- R11: `resp_valid` is a single-cycle pulse per walk, and it comes after all memory traffic of that walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle; request accepted this cycle |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Access is a write (sets dirty) |
| ptbr | input | 32 | Physical base of the first-level table (bits 31:12 used) |
| resp_valid | output | 1 | Result pulse |
| resp_fault | output | 1 | Walk hit an invalid entry |
| resp_level | output | 1 | Level of the faulting entry (0 first, 1 second) |
| resp_paddr | output | 32 | Translated physical address |
| mem_valid | output | 1 | Memory request present |
| mem_ready | input | 1 | Memory accepts the request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of the entry |
| mem_wdata | output | 32 | Updated entry for write-back |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Read data |

## Verification
The assertions assume the memory returns exactly one response for each accepted read, at some later cycle, and never sends a response that was not requested. They also assume `ptbr` and the request fields stay meaningful only at acceptance. The bench memory model keeps to this. It stalls `mem_ready` at random but returns read data one cycle after each accepted read, and it keeps a sparse table in which unmapped addresses read as invalid entries. Random walks over partly populated tables are mixed with directed cases for faults at each level, write-backs that are skipped, and a request held through a busy walk.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    parameter int VA_W   = 32;
    parameter int PA_W   = 32;
    parameter int OFF_W  = 12;
    parameter int IDX_W  = 10;
    parameter int LEVELS = 2;
    parameter int PTE_W  = 32;

    localparam int FRAME_W = PA_W - OFF_W;
    localparam int LVL_W   = (LEVELS > 1) ? $clog2(LEVELS) : 1;
    localparam int RSV_W   = PTE_W - FRAME_W - 3;
    localparam int ENT_SH  = $clog2(PTE_W / 8);

    typedef struct packed {
        logic [FRAME_W-1:0] frame;
        logic [RSV_W-1:0]   rsvd;
        logic               dirty;
        logic               used;
        logic               valid;
    } pte_t;

    typedef enum logic [2:0] {
        WS_IDLE,
        WS_RD_REQ,
        WS_RD_WAIT,
        WS_WB,
        WS_DONE
    } walk_state_e;

    // Byte address of entry idx inside the table that starts at frame
    function automatic logic [PA_W-1:0] entry_addr(logic [FRAME_W-1:0] frame,
                                                    logic [IDX_W-1:0] idx);
        logic [OFF_W-1:0] off;
        off = OFF_W'(idx) << ENT_SH;
        return {frame, off};
    endfunction
endpackage

// File: rtl/ptw_index_sel.sv
module ptw_index_sel
    import ptw_pkg::*;
(
    input  logic [VA_W-1:0]  vaddr,
    input  logic [LVL_W-1:0] level,
    output logic [IDX_W-1:0] idx
);
    logic [IDX_W-1:0] idx_arr [LEVELS];

    for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
        assign idx_arr[g] = vaddr[OFF_W + (LEVELS-1-g)*IDX_W +: IDX_W];
    end

    assign idx = idx_arr[level];
endmodule

// File: rtl/ptw_pte_mark.sv
module ptw_pte_mark
    import ptw_pkg::*;
(
    input  pte_t cur,
    input  logic is_write,
    output pte_t upd,
    output logic changed
);
    always_comb begin
        upd       = cur;
        upd.used  = 1'b1;
        upd.dirty = cur.dirty | is_write;
        changed   = (upd.used != cur.used) || (upd.dirty != cur.dirty);
    end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic              req_write,
    input  logic [PA_W-1:0]   ptbr,
    output logic              resp_valid,
    output logic              resp_fault,
    output logic [LVL_W-1:0]  resp_level,
    output logic [PA_W-1:0]   resp_paddr,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic              mem_we,
    output logic [PA_W-1:0]   mem_addr,
    output logic [PTE_W-1:0]  mem_wdata,
    input  logic              mem_rsp_valid,
    input  logic [PTE_W-1:0]  mem_rsp_data
);
    localparam logic [LVL_W-1:0] LEAF = LVL_W'(LEVELS - 1);

    walk_state_e        state_q;
    logic [VA_W-1:0]    va_q;
    logic               wr_q;
    logic [FRAME_W-1:0] base_q;
    logic [LVL_W-1:0]   lvl_q;
    pte_t               wb_q;
    logic               fault_q;
    logic [PA_W-1:0]    paddr_q;

    logic [IDX_W-1:0]   cur_idx;
    pte_t               rd_pte;
    pte_t               marked;
    logic               need_wb;

    assign rd_pte = pte_t'(mem_rsp_data);

    ptw_index_sel u_idx (
        .vaddr (va_q),
        .level (lvl_q),
        .idx   (cur_idx)
    );

    ptw_pte_mark u_mark (
        .cur      (rd_pte),
        .is_write (wr_q),
        .upd      (marked),
        .changed  (need_wb)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= WS_IDLE;
            va_q    <= '0;
            wr_q    <= 1'b0;
            base_q  <= '0;
            lvl_q   <= '0;
            wb_q    <= '0;
            fault_q <= 1'b0;
            paddr_q <= '0;
        end else begin
            case (state_q)
                WS_IDLE: begin
                    if (req_valid) begin
                        va_q    <= req_vaddr;
                        wr_q    <= req_write;
                        base_q  <= ptbr[PA_W-1:OFF_W];
                        lvl_q   <= '0;
                        fault_q <= 1'b0;
                        state_q <= WS_RD_REQ;
                    end
                end
                WS_RD_REQ: begin
                    if (mem_ready) state_q <= WS_RD_WAIT;
                end
                WS_RD_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (!rd_pte.valid) begin
                            fault_q <= 1'b1;
                            state_q <= WS_DONE;
                        end else if (lvl_q == LEAF) begin
                            paddr_q <= {rd_pte.frame, va_q[OFF_W-1:0]};
                            wb_q    <= marked;
                            state_q <= need_wb ? WS_WB : WS_DONE;
                        end else begin
                            base_q  <= rd_pte.frame;
                            lvl_q   <= lvl_q + 1'b1;
                            state_q <= WS_RD_REQ;
                        end
                    end
                end
                WS_WB: begin
                    if (mem_ready) state_q <= WS_DONE;
                end
                WS_DONE: state_q <= WS_IDLE;
                default: state_q <= WS_IDLE;
            endcase
        end
    end

    assign req_ready  = (state_q == WS_IDLE);
    assign mem_valid  = (state_q == WS_RD_REQ) || (state_q == WS_WB);
    assign mem_we     = (state_q == WS_WB);
    assign mem_addr   = entry_addr(base_q, cur_idx);
    assign mem_wdata  = wb_q;
    assign resp_valid = (state_q == WS_DONE);
    assign resp_fault = fault_q;
    assign resp_level = lvl_q;
    assign resp_paddr = paddr_q;
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk
    import ptw_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             req_ready,
    input logic             resp_valid,
    input logic             mem_valid,
    input logic             mem_ready,
    input logic             mem_we,
    input logic [PA_W-1:0]  mem_addr,
    input logic [PTE_W-1:0] mem_wdata
);
    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (req_ready && !mem_valid && !resp_valid));

    // R10
    mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)
                                       && $stable(mem_we) && $stable(mem_wdata)));

    // R11
    resp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        resp_valid |=> !resp_valid);

    // R11
    resp_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> !mem_valid);

    // R9
    busy_no_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_valid || resp_valid) |-> !req_ready);

    // R7
    wb_marked_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && mem_we) |-> (mem_wdata[0] && mem_wdata[1]));
endmodule

bind ptw_walker ptw_walker_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_ready  (req_ready),
    .resp_valid (resp_valid),
    .mem_valid  (mem_valid),
    .mem_ready  (mem_ready),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata)
);

// File: tb/ptw_walker_tb.sv
`timescale 1ns/1ps
module ptw_walker_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic [31:0] ptbr = 32'h0010_0000;
    logic        resp_valid, resp_fault;
    logic [0:0]  resp_level;
    logic [31:0] resp_paddr;
    logic        mem_valid, mem_we;
    logic        mem_ready = 1'b0;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    ptw_walker u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_write(req_write), .ptbr(ptbr),
        .resp_valid(resp_valid), .resp_fault(resp_fault), .resp_level(resp_level),
        .resp_paddr(resp_paddr), .mem_valid(mem_valid), .mem_ready(mem_ready),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    // Sparse memory model; unmapped words read as zero (invalid entry)
    logic [31:0] mem [int unsigned];
    int          rd_total = 0;
    int          wr_total = 0;
    logic [31:0] rd_log [4];
    logic [31:0] wr_addr_last = '0;

    function automatic logic [31:0] mread(logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    always @(posedge clk) begin
        mem_rsp_valid <= 1'b0;
        if (!rst && mem_valid && mem_ready) begin
            if (mem_we) begin
                mem[mem_addr] = mem_wdata;
                wr_addr_last  = mem_addr;
                wr_total      = wr_total + 1;
            end else begin
                rd_log[rd_total % 4] = mem_addr;
                rd_total      = rd_total + 1;
                mem_rsp_valid <= 1'b1;
                mem_rsp_data  <= mread(mem_addr);
            end
        end
        mem_ready <= ($urandom % 4) != 0;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Runs one walk and checks every observable result against a model
    task automatic walk(input logic [31:0] va, input bit wr, input bit hold_busy);
        logic [31:0] l1a, e1, l2a, e2, nv;
        int exp_rd, exp_wr, rd0, wr0, to;
        bit exp_fault, exp_lvl;
        l1a = {ptbr[31:12], va[31:22], 2'b00};
        e1  = mread(l1a);
        l2a = {e1[31:12], va[21:12], 2'b00};
        e2  = mread(l2a);
        nv  = e2 | 32'h2 | (wr ? 32'h4 : 32'h0);
        exp_lvl = 1'b0; exp_wr = 0;
        if (!e1[0]) begin
            exp_fault = 1; exp_rd = 1;
        end else if (!e2[0]) begin
            exp_fault = 1; exp_rd = 2; exp_lvl = 1'b1;
        end else begin
            exp_fault = 0; exp_rd = 2; exp_wr = (nv != e2) ? 1 : 0;
        end
        rd0 = rd_total; wr0 = wr_total;
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_write = wr;
        to = 0;
        while (!req_ready && to < 200) begin @(negedge clk); to++; end
        @(negedge clk);
        if (!hold_busy) req_valid = 1'b0;
        else req_vaddr = va ^ 32'h0040_0000;
        to = 0;
        while (!resp_valid && to < 400) begin @(negedge clk); to++; end
        req_valid = 1'b0;
        check(resp_valid, "R11", "resp_valid seen", 32'(resp_valid), 32'h1);
        check(resp_fault == exp_fault, exp_lvl ? "R5" : "R4", "fault",
              32'(resp_fault), 32'(exp_fault));
        if (exp_fault)
            check(resp_level == exp_lvl, exp_lvl ? "R5" : "R4", "level",
                  32'(resp_level), 32'(exp_lvl));
        else
            check(resp_paddr == {e2[31:12], va[11:0]}, "R6", "paddr",
                  resp_paddr, {e2[31:12], va[11:0]});
        check(rd_total - rd0 == exp_rd, "R4", "read count",
              32'(rd_total - rd0), 32'(exp_rd));
        check(rd_log[rd0 % 4] == l1a, "R2", "first read addr", rd_log[rd0 % 4], l1a);
        if (exp_rd == 2)
            check(rd_log[(rd0 + 1) % 4] == l2a, "R3", "second read addr",
                  rd_log[(rd0 + 1) % 4], l2a);
        check(wr_total - wr0 == exp_wr, "R8", "write count",
              32'(wr_total - wr0), 32'(exp_wr));
        if (exp_wr == 1) begin
            check(mread(l2a) == nv, "R7", "written entry", mread(l2a), nv);
            check(wr_addr_last == l2a, "R8", "write addr", wr_addr_last, l2a);
        end
        @(negedge clk);
        check(!resp_valid, "R11", "pulse length", 32'(resp_valid), 32'h0);
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int rd0;
        void'($urandom(32'd2024));
        // Build tables: first-level indices 0..15 partly valid
        for (int i = 0; i < 16; i++) begin
            if (i == 3 || ($urandom % 4) != 0) begin
                mem[{20'h00100, 10'(i), 2'b00}] = {20'h00200 + 20'(i), 12'h001};
                for (int j = 0; j < 32; j++)
                    mem[{20'h00200 + 20'(i), 10'(j), 2'b00}] =
                        {20'($urandom), 9'h0, 1'($urandom), 1'($urandom),
                         1'(($urandom % 4) != 0)};
            end else begin
                mem[{20'h00100, 10'(i), 2'b00}] = 32'h0;
            end
        end
        repeat (3) @(negedge clk);
        // R1 reset state
        check(req_ready && !resp_valid && !mem_valid, "R1", "reset outputs",
              {29'h0, req_ready, resp_valid, mem_valid}, 32'h4);
        @(negedge clk); rst = 1'b0;
        check(req_ready && !resp_valid && !mem_valid, "R1", "after reset",
              {29'h0, req_ready, resp_valid, mem_valid}, 32'h4);

        // Directed: L1 fault (index 20 unmapped) - R4
        walk({10'd20, 10'd1, 12'h123}, 1'b0, 1'b0);
        // Directed: L2 fault - R5
        mem[{20'h00203, 10'd5, 2'b00}] = 32'hABCDE000;
        walk({10'd3, 10'd5, 12'h010}, 1'b1, 1'b0);
        // Directed: clean unused read -> used set - R7
        mem[{20'h00203, 10'd6, 2'b00}] = 32'h12345001;
        walk({10'd3, 10'd6, 12'hFFF}, 1'b0, 1'b0);
        // Same read again: no change, no write - R8
        walk({10'd3, 10'd6, 12'h000}, 1'b0, 1'b0);
        // Write on used clean entry -> dirty set - R7
        walk({10'd3, 10'd6, 12'h456}, 1'b1, 1'b0);
        // Repeated write: no write-back - R8
        walk({10'd3, 10'd6, 12'h457}, 1'b1, 1'b0);
        // Request held while busy starts nothing - R9
        mem[{20'h00203, 10'd7, 2'b00}] = 32'h00777007;
        walk({10'd3, 10'd7, 12'h001}, 1'b0, 1'b1);
        rd0 = rd_total;
        repeat (6) @(negedge clk);
        check(rd_total == rd0 && req_ready, "R9", "no extra walk",
              32'(rd_total - rd0), 32'h0);

        // Random walks
        for (int n = 0; n < 300; n++)
            walk({10'($urandom % 18), 10'($urandom % 34), 12'($urandom)},
                 1'($urandom), 1'b0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule